// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the timer slice of a local interrupt controller. Software programs a 32-bit timer entry that holds the interrupt vector, the delivery mode, the trigger type, a mask bit and a periodic bit. It then writes an initial count. The current count steps down by one on each cycle in which the `tick` enable is high. When the count steps from one to zero the timer expires. If the mask bit is clear, the block sends a one-cycle request that carries the vector, mode and trigger type to the pending-interrupt logic.

After an expiry the periodic bit decides what happens next. When it is set, the counter reloads from the stored initial count and keeps running. When it is clear, the timer stays idle at zero until the initial count is written again. A masked expiry follows the same reload rule but sends no request. A register port lets software write the entry and the initial count and read back the entry, the initial count and the current count. The clock divider, bus decoding and message delivery are outside this block.

Top module: `lint_timer_top`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (only the mask bit, bit 16, set), the initial and current counts read zero, read address 3 returns zero and `irq_valid` is low.
- R2: Entry fields are vector bits 7:0, delivery mode bits 10:8, polarity bit 13, trigger bit 15 (1 = level), mask bit 16 and periodic bit 17. Bits 12 and 14 and every other bit are read-only and read as zero. A write of all ones to the entry reads back as 0x0003_A7FF.
- R3: A write to address 1 (initial count) loads both the stored initial count and the current count (address 2). A nonzero value starts the timer. While the timer runs, the current count drops by one on every cycle with `tick` high and holds on every cycle with `tick` low.
- R4: Writing zero to the initial count stops the timer. The current count then reads zero, and no request follows however many ticks arrive.
- R5: A tick that takes a running count from 1 to 0 is an expiry. With the mask bit clear, `irq_valid` is high in the following cycle for exactly that one cycle, with `irq_vector`, `irq_mode` and `irq_level` equal to the entry's vector, mode and trigger bit. Outside a request these three outputs are zero.
- R6: An expiry with the mask bit set raises no request.
- R7: An expiry with the periodic bit clear leaves the current count at zero and the timer idle. Later ticks raise no request.
- R8: An expiry with the periodic bit set reloads the current count from the initial count and the countdown continues. This holds whether the mask bit is set or clear.
- R9: An initial-count write in the same cycle as a tick takes priority: the current count takes the written value with no decrement and no expiry.
- R10: Writes to address 2 (current count) and address 3 have no effect on any readable register.
- R11: An entry write in the same cycle as an expiry takes effect after it; the request carries the entry value that was in place before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Countdown enable, one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 entry, 1 initial count, 2 current count, 3 unused |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |
| irq_mode | output | 3 | Delivery mode carried with the request |
| irq_level | output | 1 | Trigger type carried with the request, 1 = level |

## Verification
On every cycle the assertions check the following: the count holds without a tick, it steps down by exactly one when running above one, an idle timer sits at zero, a one-shot expiry goes idle, a periodic expiry reloads, a masked expiry stays silent and the request fields are zero outside a request. Only the bench scenarios can show the register read-back masking, the end-to-end timing from an initial-count write to the request, the write-over-tick priority and the use of the old entry when an entry write lands on an expiry. The bench compares every port against a cycle model under random writes and ticks, and also runs directed one-shot, periodic, masked and stop sequences.

// File: rtl/lint_pkg.sv
package lint_pkg;
  localparam int REG_W = 32;

  // entry field positions (software-visible layout)
  localparam int E_VEC_LO   = 0;
  localparam int E_MODE_LO  = 8;
  localparam int E_POL_BIT  = 13;
  localparam int E_TRIG_BIT = 15;
  localparam int E_MASK_BIT = 16;
  localparam int E_PER_BIT  = 17;

  localparam logic [REG_W-1:0] E_WR_MASK = 32'h0003_A7FF;
  localparam logic [REG_W-1:0] E_RST_VAL = 32'h0001_0000;

  typedef enum logic [1:0] {
    AD_ENTRY = 2'd0,
    AD_INIT  = 2'd1,
    AD_CUR   = 2'd2,
    AD_NONE  = 2'd3
  } lint_addr_e;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] mode;
    logic       level;
    logic       mask;
    logic       periodic;
  } lint_cfg_t;
endpackage

// File: rtl/lint_rst_sync.sv
module lint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/lint_entry_reg.sv
module lint_entry_reg
  import lint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             wr_entry,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] entry_q,
  output lint_cfg_t        cfg
);
  logic [REG_W-1:0] entry_d;
  logic             entry_en;

  always_comb begin
    entry_en = wr_entry;
    entry_d  = wr_data & E_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       entry_q <= E_RST_VAL;
    else if (entry_en) entry_q <= entry_d;
  end

  always_comb begin
    cfg.vector   = entry_q[E_VEC_LO +: 8];
    cfg.mode     = entry_q[E_MODE_LO +: 3];
    cfg.level    = entry_q[E_TRIG_BIT];
    cfg.mask     = entry_q[E_MASK_BIT];
    cfg.periodic = entry_q[E_PER_BIT];
  end

  // R2: read-only status bits never become set
  p_ro_bits_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_entry |=> (entry_q[12] == 1'b0 && entry_q[14] == 1'b0));
endmodule

// File: rtl/lint_counter.sv
module lint_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur_q,
  output logic [CNT_W-1:0] init_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cur_d, init_d;
  logic             step;

  always_comb begin
    step   = tick && run_q && !load;
    expire = step && (cur_q == ONE);
    cur_d  = cur_q;
    run_d  = run_q;
    init_d = init_q;
    if (load) begin
      init_d = load_val;
      cur_d  = load_val;
      run_d  = (load_val != '0);
    end else if (expire) begin
      if (periodic) begin
        cur_d = init_q;
      end else begin
        cur_d = '0;
        run_d = 1'b0;
      end
    end else if (step) begin
      cur_d = cur_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cur_q  <= '0;
      init_q <= '0;
      run_q  <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      init_q <= init_d;
      run_q  <= run_d;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!tick && !load) |=> $stable(cur_q));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && run_q && !load && cur_q > ONE) |=> (cur_q == $past(cur_q) - ONE));
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    !run_q |-> (cur_q == '0));
  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (expire && !periodic) |=> !run_q);
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (expire && periodic) |=> (cur_q == $past(init_q)));
endmodule

// File: rtl/lint_req_gen.sv
module lint_req_gen
  import lint_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sn,
  input  logic      expire,
  input  lint_cfg_t cfg,
  output logic      irq_valid,
  output logic [7:0] irq_vector,
  output logic [2:0] irq_mode,
  output logic      irq_level
);
  logic       fire;
  logic [7:0] vec_d;
  logic [2:0] mode_d;
  logic       lvl_d;

  always_comb begin
    fire   = expire && !cfg.mask;
    vec_d  = fire ? cfg.vector : 8'h00;
    mode_d = fire ? cfg.mode   : 3'h0;
    lvl_d  = fire ? cfg.level  : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_mode   <= '0;
      irq_level  <= 1'b0;
    end else begin
      irq_valid  <= fire;
      irq_vector <= vec_d;
      irq_mode   <= mode_d;
      irq_level  <= lvl_d;
    end
  end

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (expire && cfg.mask) |=> !irq_valid);
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    !irq_valid |-> (irq_vector == 8'h00 && irq_mode == 3'h0 && !irq_level));
  p_no_spur_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    !expire |=> !irq_valid);
endmodule

// File: rtl/lint_timer_top.sv
module lint_timer_top
  import lint_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_valid,
  output logic [7:0]  irq_vector,
  output logic [2:0]  irq_mode,
  output logic        irq_level
);
  logic             rst_sn;
  logic             wr_entry, wr_init;
  logic [REG_W-1:0] entry_q;
  lint_cfg_t        cfg;
  logic [CNT_W-1:0] cur_q, init_q;
  logic             expire;

  lint_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  always_comb begin
    wr_entry = wr_en && (wr_addr == AD_ENTRY);
    wr_init  = wr_en && (wr_addr == AD_INIT);
  end

  lint_entry_reg u_entry (
    .clk(clk), .rst_sn(rst_sn), .wr_entry(wr_entry),
    .wr_data(wr_data), .entry_q(entry_q), .cfg(cfg));

  lint_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_sn(rst_sn), .tick(tick), .load(wr_init),
    .load_val(wr_data[CNT_W-1:0]), .periodic(cfg.periodic),
    .cur_q(cur_q), .init_q(init_q), .expire(expire));

  lint_req_gen u_req (
    .clk(clk), .rst_sn(rst_sn), .expire(expire), .cfg(cfg),
    .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_mode(irq_mode), .irq_level(irq_level));

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AD_ENTRY: rd_data = entry_q;
      AD_INIT:  rd_data[CNT_W-1:0] = init_q;
      AD_CUR:   rd_data[CNT_W-1:0] = cur_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: tb/sim_lint_timer_top.sv
`timescale 1ns/1ps
module sim_lint_timer_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        irq_valid, irq_level;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // cycle model state
  logic [31:0] m_entry, m_init, m_cur;
  logic        m_run;
  logic        e_valid, e_level;
  logic [7:0]  e_vec;
  logic [2:0]  e_mode;

  always #2.5 clk = ~clk;

  lint_timer_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_mode(irq_mode), .irq_level(irq_level));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.2;
    v = rd_data;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    chk(tag, "irq_valid", {31'd0, irq_valid}, {31'd0, e_valid});
    chk(tag, "irq_vector", {24'd0, irq_vector}, {24'd0, e_vec});
    chk(tag, "irq_mode", {29'd0, irq_mode}, {29'd0, e_mode});
    chk(tag, "irq_level", {31'd0, irq_level}, {31'd0, e_level});
    rd(2'd0, v); chk(tag, "entry", v, m_entry);
    rd(2'd1, v); chk(tag, "init", v, m_init);
    rd(2'd2, v); chk(tag, "cur", v, m_cur);
    rd(2'd3, v); chk(tag, "addr3", v, 32'd0);
  endtask

  function automatic void model_step(logic w, logic [1:0] a, logic [31:0] d, logic t);
    logic [31:0] old_entry;
    old_entry = m_entry;
    e_valid = 0; e_vec = 0; e_mode = 0; e_level = 0;
    if (w && a == 2'd1) begin
      m_init = d; m_cur = d; m_run = (d != 0);
    end else if (t && m_run) begin
      if (m_cur == 1) begin
        if (!old_entry[16]) begin
          e_valid = 1; e_vec = old_entry[7:0];
          e_mode = old_entry[10:8]; e_level = old_entry[15];
        end
        if (old_entry[17]) m_cur = m_init;
        else begin m_cur = 0; m_run = 0; end
      end else m_cur = m_cur - 1;
    end
    if (w && a == 2'd0) m_entry = d & 32'h0003_A7FF;
  endfunction

  // drive at a falling edge, model the rising edge, check at the next falling edge
  task automatic cyc(logic w, logic [1:0] a, logic [31:0] d, logic t, string tag);
    wr_en = w; wr_addr = a; wr_data = d; tick = t;
    model_step(w, a, d, t);
    @(negedge clk);
    wr_en = 0; tick = 0;
    check_all(tag);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    m_entry = 32'h0001_0000; m_init = 0; m_cur = 0; m_run = 0;
    e_valid = 0; e_vec = 0; e_mode = 0; e_level = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2: field masking on write
    cyc(1, 2'd0, 32'hFFFF_FFFF, 0, "R2");
    chk("R2", "all-ones entry", m_entry, 32'h0003_A7FF);
    // R10: writes to current count and unused address ignored
    cyc(1, 2'd2, 32'h1234_5678, 0, "R10");
    cyc(1, 2'd3, 32'hDEAD_BEEF, 0, "R10");

    // R3/R5/R7: unmasked one-shot, vector 0x42, mode 5, level
    cyc(1, 2'd0, 32'h0000_8542, 0, "R2");
    cyc(1, 2'd1, 32'd3, 0, "R3");
    cyc(0, 2'd0, 0, 0, "R3");
    cyc(0, 2'd0, 0, 1, "R3");
    cyc(0, 2'd0, 0, 1, "R3");
    cyc(0, 2'd0, 0, 1, "R5");
    chk("R5", "expected pulse", {31'd0, e_valid}, 32'd1);
    cyc(0, 2'd0, 0, 0, "R5");
    repeat (4) cyc(0, 2'd0, 0, 1, "R7");

    // R8/R6: masked periodic keeps reloading silently
    cyc(1, 2'd0, 32'h0003_0011, 0, "R8");
    cyc(1, 2'd1, 32'd2, 0, "R8");
    repeat (7) cyc(0, 2'd0, 0, 1, "R6 R8");
    // unmasked periodic with count 1: request every tick
    cyc(1, 2'd0, 32'h0002_0377, 0, "R8");
    cyc(1, 2'd1, 32'd1, 0, "R8");
    repeat (3) cyc(0, 2'd0, 0, 1, "R5 R8");

    // R9: init write with tick in the same cycle
    cyc(1, 2'd1, 32'd5, 1, "R9");
    cyc(1, 2'd1, 32'd1, 1, "R9");
    // R11: entry write on an expiry cycle keeps old entry for the request
    cyc(1, 2'd0, 32'h0001_00AA, 1, "R11");
    cyc(0, 2'd0, 0, 1, "R11");
    // R4: stop
    cyc(1, 2'd1, 32'd0, 0, "R4");
    repeat (5) cyc(0, 2'd0, 0, 1, "R4");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic w, t;
      logic [1:0] a;
      logic [31:0] d;
      w = ($urandom_range(0, 9) == 0);
      a = 2'($urandom_range(0, 3));
      t = ($urandom_range(0, 9) < 6);
      if (a == 2'd1) d = 32'($urandom_range(0, 7));
      else           d = $urandom();
      cyc(w, a, d, t, "R3 R5 R6 R7 R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end
endmodule